// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits between two active-low external interrupt pins and the interrupt controller of an 8-bit microcontroller core. It samples each pin once per machine cycle, when a one-clock strobe arrives. Each pin has its own trigger-mode bit.

In level mode the request follows the latest sample, so a pin that is still low after service asks again. In edge mode a high sample followed by a low sample sets a sticky flag. The flag is cleared by a one-cycle acknowledge that the core gives when it enters the matching service routine.

Pin 1 passes through a glitch filter before sampling. Pin 0 feeds the sampler directly. While the core sleeps, an enabled level-mode request raises a wake-up line. Priority and vectoring are handled elsewhere. No data stream passes through the block, so every pin is a plain control or status signal and none has a valid/ready handshake.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, with both pins held high (1 = inactive), `req_flag`, `irq_out` and `wake` are all 0, and they stay 0 across strobes while the pins stay high.
- R2: With `edge_mode[i]`=0 (level), `req_flag[i]` is 1 exactly when the most recent strobe sample of pin i was low. The flag settles within two clocks of the strobe.
- R3: With `edge_mode[i]`=1, a high sample followed by a low sample on the next strobe sets `req_flag[i]`. The flag then stays set even after the pin returns high.
- R4: An `ack[i]` pulse clears a set edge-mode flag on the following clock. In level mode `ack[i]` has no effect, and a pin still low keeps requesting.
- R5: If a new falling edge is detected in the same clock as `ack[i]`, the edge-mode flag stays set.
- R6: Pin activity between strobes never changes the sampled state or the flags.
- R7: `irq_out[i]` = `req_flag[i]` AND `irq_en[i]`. Clearing the enable hides the request without losing an edge flag.
- R8: `wake` is 1 only while `sleep`=1 and some pin is enabled, in level mode and sampled low. An edge-mode flag never raises `wake`.
- R9: Pin 1 accepts a new level only after it has been stable for FILT_CLKS clocks (default 3), so shorter pulses are rejected. Pin 0 has no filter and catches the same pulse when strobed.
- R10: A `mode_wr[i]` pulse reloads the previous-sample register of pin i from its current sample. A mode change made just after a strobe therefore cannot create a false edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_strobe | input | 1 | One-clock machine-cycle sample strobe |
| pin_n | input | N_PINS | External interrupt pins, active low |
| edge_mode | input | N_PINS | Per-pin trigger select: 0 level, 1 falling edge |
| mode_wr | input | N_PINS | Pulse when software writes a pin's mode bit |
| irq_en | input | N_PINS | Per-pin interrupt enable |
| ack | input | N_PINS | One-clock service-entry acknowledge |
| sleep | input | 1 | Core is in idle or power-down |
| req_flag | output | N_PINS | Raw request flags |
| irq_out | output | N_PINS | Enabled requests to the controller |
| wake | output | 1 | Wake-up request |

## Verification
The main function is tried with four kinds of pin activity.

- **Slow level changes in level mode** show that the flag tracks the sample and that an acknowledge does nothing there.
- **High-then-low pairs in edge mode** show that the flag is sticky until acknowledged, including when the edge and the acknowledge fall in the same clock.
- **Changes made between strobes** tell sampled behaviour apart from combinational tracking.
- **A two-clock low pulse on both pins under a continuous strobe** shows that the filter on pin 1 rejects what pin 0 catches.

A mode write timed just after a strobe shows the false edge being suppressed.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

  localparam logic PIN_IDLE = 1'b1;
endpackage

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter #(
  parameter int STABLE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic clean_n
);
  import ext_irq_pkg::*;
  localparam int CW = $clog2(STABLE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CLKS - 1);

  logic [CW-1:0] run_cnt;

  // a differing level must persist STABLE_CLKS clocks before it is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_n <= PIN_IDLE;
      run_cnt <= '0;
    end else if (raw_n == clean_n) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      clean_n <= raw_n;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic pin_n,
  input  logic mode_wr,
  output logic smp_n,
  output logic fall
);
  import ext_irq_pkg::*;
  logic prev_n;
  logic fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_n  <= PIN_IDLE;
      prev_n <= PIN_IDLE;
      fresh  <= 1'b0;
    end else begin
      fresh <= strobe;
      if (strobe) begin
        smp_n  <= pin_n;
        prev_n <= smp_n;
      end else if (mode_wr) begin
        prev_n <= smp_n;
      end
    end
  end

  // a falling pair is reported once, in the clock after the strobe
  assign fall = fresh & prev_n & ~smp_n & ~mode_wr;
endmodule

// File: rtl/irq_req_flag.sv
module irq_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  ext_irq_pkg::trig_mode_e mode,
  input  logic smp_n,
  input  logic fall,
  input  logic ack,
  output logic flag
);
  import ext_irq_pkg::*;
  logic sticky;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sticky <= 1'b0;
    else if (mode != TRIG_EDGE) sticky <= 1'b0;
    else if (fall)            sticky <= 1'b1;
    else if (ack)             sticky <= 1'b0;
  end

  assign flag = (mode == TRIG_EDGE) ? sticky : ~smp_n;
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int N_PINS    = 2,
  parameter int FILT_PIN  = 1,
  parameter int FILT_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_strobe,
  input  logic [N_PINS-1:0] pin_n,
  input  logic [N_PINS-1:0] edge_mode,
  input  logic [N_PINS-1:0] mode_wr,
  input  logic [N_PINS-1:0] irq_en,
  input  logic [N_PINS-1:0] ack,
  input  logic              sleep,
  output logic [N_PINS-1:0] req_flag,
  output logic [N_PINS-1:0] irq_out,
  output logic              wake
);
  import ext_irq_pkg::*;

  logic [N_PINS-1:0] pin_clean_n;
  logic [N_PINS-1:0] smp_n;
  logic [N_PINS-1:0] fall;
  logic [N_PINS-1:0] lvl_wake;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    if (i == FILT_PIN) begin : g_filt
      irq_glitch_filter #(.STABLE_CLKS(FILT_CLKS)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_n(pin_n[i]), .clean_n(pin_clean_n[i])
      );
    end else begin : g_direct
      assign pin_clean_n[i] = pin_n[i];
    end

    irq_pin_sampler u_smp (
      .clk(clk), .rst_n(rst_n), .strobe(mc_strobe), .pin_n(pin_clean_n[i]),
      .mode_wr(mode_wr[i]), .smp_n(smp_n[i]), .fall(fall[i])
    );

    irq_req_flag u_flag (
      .clk(clk), .rst_n(rst_n), .mode(trig_mode_e'(edge_mode[i])),
      .smp_n(smp_n[i]), .fall(fall[i]), .ack(ack[i]), .flag(req_flag[i])
    );

    assign lvl_wake[i] = irq_en[i] & ~edge_mode[i] & ~smp_n[i];
  end

  assign irq_out = req_flag & irq_en;
  assign wake    = sleep & (|lvl_wake);
endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
  parameter int N_PINS   = 2,
  parameter int FILT_PIN = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mc_strobe,
  input logic [N_PINS-1:0] pin_n,
  input logic [N_PINS-1:0] edge_mode,
  input logic [N_PINS-1:0] irq_en,
  input logic [N_PINS-1:0] ack,
  input logic              sleep,
  input logic [N_PINS-1:0] req_flag,
  input logic              wake,
  input logic [N_PINS-1:0] filt_n
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[i] && req_flag[i] && !ack[i]) |=> (req_flag[i] || !edge_mode[i]));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[i] && ack[i] && !$past(mc_strobe)) |=> (!req_flag[i] || !edge_mode[i]));

    assert_no_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(mc_strobe) && !edge_mode[i] && !$past(edge_mode[i])) |-> $stable(req_flag[i]));
  end

  assert_wake_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (sleep && |(irq_en & ~edge_mode & req_flag)));

  assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_n[FILT_PIN]) |-> ($past(pin_n[FILT_PIN]) == filt_n[FILT_PIN]));
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.N_PINS(N_PINS), .FILT_PIN(FILT_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe), .pin_n(pin_n),
  .edge_mode(edge_mode), .irq_en(irq_en), .ack(ack), .sleep(sleep),
  .req_flag(req_flag), .wake(wake), .filt_n(pin_clean_n)
);

// File: tb/ext_irq_cond_tb_top.sv
module ext_irq_cond_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_strobe = 1'b0;
  logic [1:0] pin_n = 2'b11;
  logic [1:0] edge_mode = 2'b00;
  logic [1:0] mode_wr = 2'b00;
  logic [1:0] irq_en = 2'b11;
  logic [1:0] ack = 2'b00;
  logic sleep = 1'b0;
  logic [1:0] req_flag;
  logic [1:0] irq_out;
  logic wake;

  always #10 clk = ~clk;

  ext_irq_cond dut_i (
    .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe), .pin_n(pin_n),
    .edge_mode(edge_mode), .mode_wr(mode_wr), .irq_en(irq_en), .ack(ack),
    .sleep(sleep), .req_flag(req_flag), .irq_out(irq_out), .wake(wake)
  );

  typedef struct {
    logic [1:0] req;
    logic [1:0] irq;
    logic       wk;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // monitor: pops each expected item and compares with the live outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (req_flag !== e.req || irq_out !== e.irq || wake !== e.wk) begin
          n_fail++;
          $display("FAIL %s: got req=%b irq=%b wake=%b, expected req=%b irq=%b wake=%b",
                   e.tag, req_flag, irq_out, wake, e.req, e.irq, e.wk);
        end
      end
    end
  end

  task automatic expect_out(input logic [1:0] r, input logic [1:0] q, input logic w,
                            input string tag);
    exp_t e;
    e.req = r; e.irq = q; e.wk = w; e.tag = tag;
    exp_q.push_back(e);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mcycle();
    @(negedge clk); mc_strobe = 1'b1;
    @(negedge clk); mc_strobe = 1'b0;
    idle(2);
  endtask

  task automatic set_pins(input logic [1:0] v);
    @(negedge clk); pin_n = v;
    idle(4);
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk); edge_mode = m; mode_wr = 2'b11;
    @(negedge clk); mode_wr = 2'b00;
  endtask

  task automatic pulse_ack(input logic [1:0] a);
    @(negedge clk); ack = a;
    @(negedge clk); ack = 2'b00;
    idle(1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_out(2'b00, 2'b00, 1'b0, "R1 reset state");
    mcycle(); mcycle();
    expect_out(2'b00, 2'b00, 1'b0, "R1 idle pins after strobes");

    // level mode tracking
    set_pins(2'b10); mcycle();
    expect_out(2'b01, 2'b01, 1'b0, "R2 level low sampled");
    set_pins(2'b11); mcycle();
    expect_out(2'b00, 2'b00, 1'b0, "R2 level released");

    // changes between strobes are invisible
    set_pins(2'b10); idle(8);
    expect_out(2'b00, 2'b00, 1'b0, "R6 no strobe no change");
    mcycle();
    expect_out(2'b01, 2'b01, 1'b0, "R6 strobe picks up level");
    set_pins(2'b11); mcycle();

    // wake from level request
    sleep = 1'b1;
    set_pins(2'b01); mcycle();
    expect_out(2'b10, 2'b10, 1'b1, "R8 level wake");
    irq_en = 2'b01; #1;
    expect_out(2'b10, 2'b00, 1'b0, "R7 R8 disabled pin masked");
    irq_en = 2'b11;
    set_pins(2'b11); mcycle();
    expect_out(2'b00, 2'b00, 1'b0, "R8 wake drops with level");
    sleep = 1'b0;

    // edge mode on pin 0
    write_mode(2'b01);
    set_pins(2'b10); mcycle();
    expect_out(2'b01, 2'b01, 1'b0, "R3 falling pair sets flag");
    set_pins(2'b11); mcycle();
    expect_out(2'b01, 2'b01, 1'b0, "R3 flag sticky after release");
    irq_en = 2'b10; #1;
    expect_out(2'b01, 2'b00, 1'b0, "R7 enable hides edge flag");
    irq_en = 2'b11; #1;
    expect_out(2'b01, 2'b01, 1'b0, "R7 edge flag kept");
    pulse_ack(2'b01);
    expect_out(2'b00, 2'b00, 1'b0, "R4 ack clears edge flag");

    // ack in level mode (pin 1)
    set_pins(2'b01); mcycle();
    pulse_ack(2'b10);
    expect_out(2'b10, 2'b10, 1'b0, "R4 level ignores ack");
    set_pins(2'b11); mcycle();

    // edge and ack in the same clock
    pulse_ack(2'b01);
    set_pins(2'b10); mcycle();
    set_pins(2'b11); mcycle();
    set_pins(2'b10);
    @(negedge clk); mc_strobe = 1'b1;
    @(negedge clk); mc_strobe = 1'b0; ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    idle(1);
    expect_out(2'b01, 2'b01, 1'b0, "R5 edge wins over ack");
    pulse_ack(2'b01);
    expect_out(2'b00, 2'b00, 1'b0, "R5 later ack clears");

    // edge flag does not wake
    sleep = 1'b1;
    set_pins(2'b11); mcycle();
    set_pins(2'b10); mcycle();
    expect_out(2'b01, 2'b01, 1'b0, "R8 edge flag no wake");
    pulse_ack(2'b01);
    sleep = 1'b0;
    set_pins(2'b11); mcycle();

    // mode write right after strobe suppresses false edge
    write_mode(2'b00);
    set_pins(2'b10);
    @(negedge clk); mc_strobe = 1'b1;
    @(negedge clk); mc_strobe = 1'b0; edge_mode = 2'b01; mode_wr = 2'b01;
    @(negedge clk); mode_wr = 2'b00;
    idle(2);
    expect_out(2'b00, 2'b00, 1'b0, "R10 mode write no false edge");
    set_pins(2'b11); mcycle();
    set_pins(2'b10); mcycle();
    expect_out(2'b01, 2'b01, 1'b0, "R10 real edge after mode write");
    pulse_ack(2'b01);

    // glitch filter on pin 1 only
    write_mode(2'b11);
    set_pins(2'b11); mcycle();
    @(negedge clk); mc_strobe = 1'b1; pin_n = 2'b00;
    idle(2);
    pin_n = 2'b11;
    idle(4);
    mc_strobe = 1'b0;
    idle(2);
    expect_out(2'b01, 2'b01, 1'b0, "R9 short pulse: pin0 caught, pin1 rejected");
    pulse_ack(2'b01);
    set_pins(2'b01); mcycle();
    expect_out(2'b10, 2'b10, 1'b0, "R9 long pulse accepted on pin1");
    pulse_ack(2'b10);
    expect_out(2'b00, 2'b00, 1'b0, "R4 ack clears pin1 edge flag");

    wait (exp_q.size() == 0);
    #1;
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end
endmodule